// File: doc/BRIEF.md
# Refresh-Synchronized Performance Throttle

This block reduces effective processor speed without touching the processor clock. Each periodic refresh strobe from the interval timer opens a hold window of programmable length. During that window the block raises a bus hold request toward the processor and, if enabled, drives an active-low cache flush line so the processor cannot keep running from its internal cache. The window length is counted on a slow time-base clock of about 8 MHz, so a 7-bit count covers up to roughly 15.9 us. The count is set just below the refresh interval to bring a fast processor down to the speed of an older machine.

Slow mode is the logical OR of a register bit and an external active-low slow pin. The pin is brought into the time-base domain through a two-flop synchronizer. The hold request and the flush output have separate enables. While hold is enabled, the window counts only the cycles on which the processor acknowledges the hold, so the programmed time is time actually spent in hold. The block only requests the hold. Other bus masters, DMA and refresh keep running on the bus during the window, because arbitration happens elsewhere.

Top module: `perf_throttle`

## Requirements
- R1: After reset the slow enable, hold enable, flush enable and count are all zero, hold_o is low and flush_no is high.
- R2: A write to address 0 sets bit 7 as the slow enable and bits 6:0 as the count N. Slow mode must be active, hold enabled and hold_ack_i high whenever hold_o is high. Under those conditions a refresh strobe sampled at a clock edge raises hold_o from that edge for exactly N cycles, for every N from 1 to 127.
- R3: A count of zero opens no window, so hold_o stays low and flush_no stays high after a refresh strobe.
- R4: Slow mode is active when the register slow enable is set or the synchronized slow_ni is low. When neither holds, a refresh strobe is ignored.
- R5: A write to address 1 sets bit 0 as the hold enable and bit 1 as the flush enable. flush_no is low for the whole window when the flush enable is set. Each output is inactive when its own enable is clear. With hold disabled, the window counts every cycle.
- R6: A refresh strobe that arrives while a window is open reloads the count to N. The window then continues with no gap, so a strobe taken k cycles after the first gives k+N hold cycles in total.
- R7: While hold is enabled the count advances only on cycles when hold_ack_i is high. If the acknowledge lags hold_o by one cycle, the window lasts N+1 cycles.
- R8: The count is captured when the refresh strobe is taken. A write to address 0 during an open window changes only later windows.
- R9: slow_ni passes through two flops. A refresh strobe in the same cycle as the fall of slow_ni, or in the next cycle, is ignored. A strobe two cycles after the fall is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time-base clock, about 8 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_req_i | input | 1 | One-cycle refresh strobe from the interval timer |
| slow_ni | input | 1 | Asynchronous external slow request, active low |
| hold_ack_i | input | 1 | Hold acknowledge from the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 duration, 1 function enables |
| wr_data_i | input | 8 | Register write data |
| hold_o | output | 1 | Hold request to the processor |
| flush_no | output | 1 | Cache flush, active low |

## Verification
The hardest case to reach from the ports is a window whose length depends on something other than N. That happens when the acknowledge lags the request, when a second strobe lands inside an open window, or when the duration register is rewritten mid-window. The bench drives the acknowledge from a small model that either follows hold_o directly or one cycle late. It places the second strobe and the register write at chosen cycle offsets inside a window, so the expected lengths N+1, k+1+N and an unchanged N can be computed exactly. The synchronizer edge is reached by dropping slow_ni and issuing the strobe zero, one and two cycles later.

// File: rtl/perf_throttle_pkg.sv
package perf_throttle_pkg;
  localparam int CNT_W_DEF = 7;
  localparam int SYNC_DEF  = 2;

  typedef enum logic {
    ADDR_DUR = 1'b0,
    ADDR_FN  = 1'b1
  } reg_addr_e;

  localparam int FN_HOLD_BIT  = 0;
  localparam int FN_FLUSH_BIT = 1;
endpackage

// File: rtl/throttle_regs.sv
module throttle_regs
  import perf_throttle_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF,
  localparam int DW   = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             slow_en_o,
  output logic [CNT_W-1:0] len_o,
  output logic             hold_en_o,
  output logic             flush_en_o
);
  logic dur_we, fn_we;
  logic unused_fn_bits;

  assign dur_we = wr_en_i && (wr_addr_i == ADDR_DUR);
  assign fn_we  = wr_en_i && (wr_addr_i == ADDR_FN);
  assign unused_fn_bits = ^wr_data_i[DW-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_en_o <= 1'b0;
      len_o     <= '0;
    end else if (dur_we) begin
      slow_en_o <= wr_data_i[DW-1];
      len_o     <= wr_data_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_en_o  <= 1'b0;
      flush_en_o <= 1'b0;
    end else if (fn_we) begin
      hold_en_o  <= wr_data_i[FN_HOLD_BIT];
      flush_en_o <= wr_data_i[FN_FLUSH_BIT];
    end
  end

  assert_dur_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dur_we |=> (len_o == $past(wr_data_i[CNT_W-1:0])) && (slow_en_o == $past(wr_data_i[DW-1])));

  assert_fn_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fn_we |=> $stable(hold_en_o) && $stable(flush_en_o));
endmodule

// File: rtl/slow_sync.sv
module slow_sync
  import perf_throttle_pkg::*;
#(
  parameter int STAGES = SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_ni,
  output logic slow_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '1;
    else         stage_q <= {stage_q[STAGES-2:0], slow_ni};
  end

  assign slow_o = ~stage_q[STAGES-1];

  assert_sync_path_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_o) |-> ($past(stage_q[0]) == 1'b0));
endmodule

// File: rtl/hold_timer.sv
module hold_timer
  import perf_throttle_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             refresh_i,
  input  logic             slow_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             hold_en_i,
  input  logic             flush_en_i,
  input  logic             hold_ack_i,
  output logic             hold_o,
  output logic             flush_no
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             load, step;

  // window opens only when it can be seen on some output
  assign load = refresh_i && slow_i && (len_i != '0) && (hold_en_i || flush_en_i);
  // time in hold counts only once granted
  assign step = active_q && (!hold_en_i || hold_ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      cnt_q    <= len_i;
      active_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) active_q <= 1'b0;
    end
  end

  assign hold_o   = active_q && hold_en_i;
  assign flush_no = !(active_q && flush_en_i);

  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> active_q && (cnt_q == $past(len_i)));

  assert_zero_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && (len_i == '0) && !active_q) |=> !active_q);

  assert_ack_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && hold_en_i && !hold_ack_i && !load) |=> $stable(cnt_q) && active_q);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !load && (cnt_q > CNT_W'(1))) |=> active_q && (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/perf_throttle.sv
module perf_throttle
  import perf_throttle_pkg::*;
#(
  parameter int CNT_W       = CNT_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF,
  localparam int DW         = CNT_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          refresh_req_i,
  input  logic          slow_ni,
  input  logic          hold_ack_i,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          hold_o,
  output logic          flush_no
);
  logic             slow_en, pin_slow, slow_active;
  logic [CNT_W-1:0] len;
  logic             hold_en, flush_en;

  throttle_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .slow_en_o  (slow_en),
    .len_o      (len),
    .hold_en_o  (hold_en),
    .flush_en_o (flush_en)
  );

  slow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slow_ni (slow_ni),
    .slow_o  (pin_slow)
  );

  assign slow_active = slow_en | pin_slow;

  hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .refresh_i  (refresh_req_i),
    .slow_i     (slow_active),
    .len_i      (len),
    .hold_en_i  (hold_en),
    .flush_en_i (flush_en),
    .hold_ack_i (hold_ack_i),
    .hold_o     (hold_o),
    .flush_no   (flush_no)
  );

  assert_full_speed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slow_en && !pin_slow && !hold_o && flush_no) |=> !hold_o && flush_no);
endmodule

// File: tb/perf_throttle_test.sv
module perf_throttle_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refresh = 1'b0;
  logic       slow_n = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       hold, flush_n, ack, ack_q;
  logic       ack_late = 1'b0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) ack_q <= hold;
  assign ack = ack_late ? ack_q : hold;

  perf_throttle uut (
    .clk_i(clk), .rst_ni(rst_n), .refresh_req_i(refresh), .slow_ni(slow_n),
    .hold_ack_i(ack), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hold_o(hold), .flush_no(flush_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // strobe at the current negedge, then count output cycles; optional
  // second strobe at iteration rk and duration write at iteration wk
  task automatic window(input int rk, input int wk, input logic [7:0] wv,
                        output int hc, output int fc);
    hc = 0; fc = 0;
    @(negedge clk);
    refresh = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      refresh = (i == rk);
      wr_en = (i == wk); wr_addr = 1'b0; wr_data = wv;
      if (hold) hc++;
      if (!flush_n) fc++;
    end
    refresh = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hc, fc;
    repeat (3) @(negedge clk);
    check(!hold && flush_n, "R1 reset outputs", {hold, flush_n}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hold && flush_n, "R1 after release", {hold, flush_n}, 1);
    wr(1'b0, 8'h05);
    window(-1, -1, 0, hc, fc);
    check(hc == 0 && fc == 0, "R1 enables cleared at reset", hc + fc, 0);

    // R2 / R5 sweep every count with both outputs enabled
    wr(1'b1, 8'h03);
    for (int n = 0; n < 128; n++) begin
      wr(1'b0, 8'h80 | 8'(n));
      window(-1, -1, 0, hc, fc);
      if (n == 0) check(hc == 0 && fc == 0, "R3 zero count", hc + fc, 0);
      else check(hc == n && fc == n, "R2 hold length", hc, n);
    end

    // R5 flush only, hold only
    wr(1'b0, 8'h8C);
    wr(1'b1, 8'h02);
    window(-1, -1, 0, hc, fc);
    check(hc == 0, "R5 hold disabled", hc, 0);
    check(fc == 12, "R5 flush only length", fc, 12);
    wr(1'b1, 8'h01);
    window(-1, -1, 0, hc, fc);
    check(fc == 0, "R5 flush disabled", fc, 0);
    check(hc == 12, "R5 hold only length", hc, 12);

    // R7 acknowledge one cycle late
    ack_late = 1'b1;
    for (int n = 1; n < 128; n += 21) begin
      wr(1'b0, 8'h80 | 8'(n));
      window(-1, -1, 0, hc, fc);
      check(hc == n + 1, "R7 late ack length", hc, n + 1);
    end
    ack_late = 1'b0;

    // R6 restart inside window
    wr(1'b0, 8'h8A);
    for (int k = 0; k < 10; k += 3) begin
      window(k, -1, 0, hc, fc);
      check(hc == k + 1 + 10, "R6 restart gapless", hc, k + 11);
    end

    // R8 rewrite during window
    window(-1, 2, 8'h83, hc, fc);
    check(hc == 10, "R8 current window unchanged", hc, 10);
    window(-1, -1, 0, hc, fc);
    check(hc == 3, "R8 new count next window", hc, 3);

    // R4 pin path, register enable clear
    wr(1'b0, 8'h05);
    window(-1, -1, 0, hc, fc);
    check(hc == 0, "R4 full speed ignores refresh", hc, 0);
    for (int d = 0; d < 3; d++) begin
      @(negedge clk);
      slow_n = 1'b0;
      // window() strobes one negedge later, so wait d-1 here
      for (int j = 0; j < d - 1; j++) @(negedge clk);
      if (d == 0) begin
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        hc = 0;
        for (int i = 0; i < 20; i++) begin
          if (hold) hc++;
          @(negedge clk);
        end
      end else window(-1, -1, 0, hc, fc);
      check(hc == ((d == 2) ? 5 : 0), "R9 synchronizer latency", hc, (d == 2) ? 5 : 0);
      slow_n = 1'b1;
      repeat (4) @(negedge clk);
    end
    slow_n = 1'b0;
    repeat (4) @(negedge clk);
    window(-1, -1, 0, hc, fc);
    check(hc == 5, "R4 pin enables slow mode", hc, 5);
    slow_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h85);
    window(-1, -1, 0, hc, fc);
    check(hc == 5, "R4 register enables slow mode", hc, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule